// File: doc/BRIEF.md
# Hardware Reset Sequencer

This block turns an active-low external reset request into a clean internal reset of fixed minimum length. The raw pin is brought into the clock domain through a multi-flop synchronizer. Once a low level is seen, a counter runs one internal sequence of `SEQ_LEN` clock cycles. When the count ends, the pin is looked at again. If it has gone inactive, the reset is short and is released. If it is still low, the reset is long and is held until the pin rises. When the clock comes from a PLL, the release also waits for the lock indicator.

A power-on indication restarts everything asynchronously and holds the internal reset for two sequences after it clears. The reset-configuration inputs feed a latch that stays closed for the first whole sequence of every reset. From then on it follows its inputs while the reset lasts, and it freezes on the edge where the reset is released. Three cause flags record whether the last reset was power-on, short or long, so software can read them once it runs.

Top module: `hwrst_seq_ctrl`

## Requirements
- R1: The pin goes through a 2-stage synchronizer. With the block idle, a low level first present before rising edge k asserts `core_rst` at edge k+2 and not earlier.
- R2: While `por` is high, these hold: `core_rst` is 1, `flag_pon` is 1, `flag_short` and `flag_long` are 0, and `cfg_q` is `CFG_RST`. With the pin high and `pll_mode` low, `core_rst` stays high for exactly 2*`SEQ_LEN` rising edges after `por` falls.
- R3: If the synchronized pin is high at the last cycle of the sequence and no lock wait applies, `core_rst` is high for exactly `SEQ_LEN` cycles and `flag_short` becomes 1 on the release edge.
- R4: If the synchronized pin is still low at the last cycle, `flag_long` becomes 1. `core_rst` then stays high until the edge that sees the synchronized pin high, so a pin held low for L ≥ `SEQ_LEN` cycles gives an internal reset of exactly L cycles.
- R5: With `pll_mode` = 1, `core_rst` is not released while `pll_lock` = 0, even after the count has ended. It is released on the first edge that samples `pll_lock` = 1. With `pll_mode` = 0, `pll_lock` has no effect.
- R6: `cfg_q` keeps its old value during the first `SEQ_LEN`-1 edges of a reset. It loads `cfg_in` on every later edge while `core_rst` is high, the release edge included. It does not change while `core_rst` is low.
- R7: A new low level on the pin during a running sequence neither restarts nor lengthens the count.
- R8: `flag_short` and `flag_long` are never 1 at the same time. All three flags are cleared on the edge where a new pin reset is recognized.
- R9: `flag_pon` is set only by `por`. Pin resets never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por | input | 1 | Power-on indication, active high, asynchronous |
| rst_pin_n | input | 1 | Raw external reset request, active low |
| pll_mode | input | 1 | 1 when the clock is generated by the PLL |
| pll_lock | input | 1 | PLL lock indicator, synchronous to `clk` |
| cfg_in | input | CFG_W | Reset-configuration input levels |
| core_rst | output | 1 | Registered internal reset, active high |
| cfg_q | output | CFG_W | Latched reset configuration |
| flag_pon | output | 1 | Last reset was power-on |
| flag_short | output | 1 | Last reset ended with the pin inactive |
| flag_long | output | 1 | Last reset was extended by the pin |

## Verification
The internal state of this block is the sequence counter, the phase register and the configuration-open bit. A wrong state shows at the ports in one of three ways. A bad count moves the falling edge of `core_rst` by that many cycles. A bad phase either leaves `core_rst` stuck high or sets the wrong cause flag on the release edge. A bad open bit lets `cfg_q` load early or miss the value present at the release edge. Each of these is visible on the first release after the fault, at most one sequence plus the extension later. For that reason the reference model is compared with all outputs on every clock, and the directed checks measure exact reset lengths.

// File: rtl/hwrst_pkg.sv
package hwrst_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEQ  = 2'd1,
      PH_PIN  = 2'd2,
      PH_LOCK = 2'd3
   } rst_phase_t;

   typedef struct packed {
      logic pon;
      logic lng;
      logic shrt;
   } cause_t;

endpackage

// File: rtl/hwrst_sync.sv
module hwrst_sync #(
   parameter int   STAGES  = 2,
   parameter logic IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or posedge arst) begin
               if (arst) chain[gi] <= IDLE_LV;
               else      chain[gi] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge arst) begin
               if (arst) chain[gi] <= IDLE_LV;
               else      chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hwrst_seq_fsm.sv
module hwrst_seq_fsm
   import hwrst_pkg::*;
#(
   parameter int SEQ_LEN = 518,
   parameter int CNT_W   = 11
) (
   input  logic clk,
   input  logic por,
   input  logic pin_s,
   input  logic pll_mode,
   input  logic pll_lock,
   output logic core_rst,
   output logic det,
   output logic end_short,
   output logic end_long,
   output logic cfg_open
);
   localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(SEQ_LEN - 1);
   localparam logic [CNT_W-1:0] LAST_TWO = CNT_W'(2 * SEQ_LEN - 1);

   rst_phase_t       ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             rst_q, rst_d;
   logic             dbl_q, dbl_d;
   logic             open_q, open_d;
   logic             seq_end, first_end, lock_wait;

   assign first_end = (ph_q == PH_SEQ) && (cnt_q == LAST_ONE);
   assign seq_end   = (ph_q == PH_SEQ) && (cnt_q == (dbl_q ? LAST_TWO : LAST_ONE));
   assign lock_wait = pll_mode && !pll_lock;

   always_comb begin
      ph_d      = ph_q;
      cnt_d     = cnt_q;
      rst_d     = rst_q;
      dbl_d     = dbl_q;
      open_d    = open_q | first_end;
      det       = 1'b0;
      end_short = 1'b0;
      end_long  = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (!pin_s) begin
               ph_d   = PH_SEQ;
               cnt_d  = '0;
               rst_d  = 1'b1;
               dbl_d  = 1'b0;
               open_d = 1'b0;
               det    = 1'b1;
            end
         end
         PH_SEQ: begin
            cnt_d = cnt_q + 1'b1;
            if (seq_end) begin
               if (!pin_s) begin
                  end_long = 1'b1;
                  ph_d     = PH_PIN;
               end else begin
                  end_short = 1'b1;
                  if (lock_wait) begin
                     ph_d = PH_LOCK;
                  end else begin
                     ph_d  = PH_IDLE;
                     rst_d = 1'b0;
                  end
               end
            end
         end
         PH_PIN: begin
            if (pin_s) begin
               if (lock_wait) begin
                  ph_d = PH_LOCK;
               end else begin
                  ph_d  = PH_IDLE;
                  rst_d = 1'b0;
               end
            end
         end
         PH_LOCK: begin
            if (!lock_wait) begin
               ph_d  = PH_IDLE;
               rst_d = 1'b0;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         ph_q   <= PH_SEQ;
         cnt_q  <= '0;
         rst_q  <= 1'b1;
         dbl_q  <= 1'b1;
         open_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         rst_q  <= rst_d;
         dbl_q  <= dbl_d;
         open_q <= open_d;
      end
   end

   assign core_rst = rst_q;
   assign cfg_open = rst_q && (open_q || first_end);
endmodule

// File: rtl/hwrst_cfg_latch.sv
module hwrst_cfg_latch #(
   parameter int             CFG_W   = 8,
   parameter logic [CFG_W-1:0] CFG_RST = '0
) (
   input  logic             clk,
   input  logic             por,
   input  logic             open,
   input  logic [CFG_W-1:0] cfg_in,
   output logic [CFG_W-1:0] cfg_q
);
   genvar bi;
   generate
      for (bi = 0; bi < CFG_W; bi++) begin : g_bit
         always_ff @(posedge clk or posedge por) begin
            if (por)       cfg_q[bi] <= CFG_RST[bi];
            else if (open) cfg_q[bi] <= cfg_in[bi];
         end
      end
   endgenerate
endmodule

// File: rtl/hwrst_cause_flags.sv
module hwrst_cause_flags
   import hwrst_pkg::*;
(
   input  logic   clk,
   input  logic   por,
   input  logic   det,
   input  logic   end_short,
   input  logic   end_long,
   output cause_t cause
);
   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         cause <= '{pon: 1'b1, lng: 1'b0, shrt: 1'b0};
      end else if (det) begin
         cause <= '0;
      end else begin
         if (end_short) cause.shrt <= 1'b1;
         if (end_long)  cause.lng  <= 1'b1;
      end
   end
endmodule

// File: rtl/hwrst_seq_ctrl.sv
module hwrst_seq_ctrl
   import hwrst_pkg::*;
#(
   parameter int               SEQ_LEN     = 518,
   parameter int               SYNC_STAGES = 2,
   parameter int               CFG_W       = 8,
   parameter logic [CFG_W-1:0] CFG_RST     = '0
) (
   input  logic             clk,
   input  logic             por,
   input  logic             rst_pin_n,
   input  logic             pll_mode,
   input  logic             pll_lock,
   input  logic [CFG_W-1:0] cfg_in,
   output logic             core_rst,
   output logic [CFG_W-1:0] cfg_q,
   output logic             flag_pon,
   output logic             flag_short,
   output logic             flag_long
);
   localparam int CNT_W = $clog2(2 * SEQ_LEN);

   generate
      if (SEQ_LEN < 4) begin : g_bad_len
         $error("SEQ_LEN must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CFG_W < 1) begin : g_bad_cfg
         $error("CFG_W must be at least 1");
      end
   endgenerate

   logic   pin_s, det, end_short, end_long, cfg_open;
   cause_t cause;

   hwrst_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
      .clk  (clk),
      .arst (por),
      .din  (rst_pin_n),
      .dout (pin_s)
   );

   hwrst_seq_fsm #(.SEQ_LEN(SEQ_LEN), .CNT_W(CNT_W)) u_fsm (
      .clk       (clk),
      .por       (por),
      .pin_s     (pin_s),
      .pll_mode  (pll_mode),
      .pll_lock  (pll_lock),
      .core_rst  (core_rst),
      .det       (det),
      .end_short (end_short),
      .end_long  (end_long),
      .cfg_open  (cfg_open)
   );

   hwrst_cfg_latch #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
      .clk    (clk),
      .por    (por),
      .open   (cfg_open),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q)
   );

   hwrst_cause_flags u_flags (
      .clk       (clk),
      .por       (por),
      .det       (det),
      .end_short (end_short),
      .end_long  (end_long),
      .cause     (cause)
   );

   assign flag_pon   = cause.pon;
   assign flag_short = cause.shrt;
   assign flag_long  = cause.lng;
endmodule

// File: rtl/hwrst_seq_chk.sv
module hwrst_seq_chk #(
   parameter int CFG_W = 8
) (
   input logic             clk,
   input logic             por,
   input logic             pll_mode,
   input logic             pll_lock,
   input logic             core_rst,
   input logic [CFG_W-1:0] cfg_q,
   input logic             flag_pon,
   input logic             flag_short,
   input logic             flag_long
);
   p_flags_excl_r8: assert property (@(posedge clk) disable iff (por)
      !(flag_short && flag_long));

   p_flags_clear_r8: assert property (@(posedge clk) disable iff (por)
      $rose(core_rst) |-> (!flag_short && !flag_long && !flag_pon));

   p_pon_only_por_r9: assert property (@(posedge clk) disable iff (por)
      !$rose(flag_pon));

   p_cause_at_release_r3: assert property (@(posedge clk) disable iff (por)
      $fell(core_rst) |-> (flag_short ^ flag_long));

   p_lock_hold_r5: assert property (@(posedge clk) disable iff (por)
      (core_rst && (flag_short || flag_long) && pll_mode && !pll_lock) |=> core_rst);

   p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (por)
      (!core_rst && $past(!core_rst)) |-> $stable(cfg_q));
endmodule

bind hwrst_seq_ctrl hwrst_seq_chk #(.CFG_W(CFG_W)) u_chk (
   .clk        (clk),
   .por        (por),
   .pll_mode   (pll_mode),
   .pll_lock   (pll_lock),
   .core_rst   (core_rst),
   .cfg_q      (cfg_q),
   .flag_pon   (flag_pon),
   .flag_short (flag_short),
   .flag_long  (flag_long)
);

// File: tb/hwrst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module hwrst_seq_ctrl_tb;
   localparam int SEQ = 518;
   localparam int CW  = 8;

   logic          clk = 1'b0;
   logic          por = 1'b1;
   logic          pin_n = 1'b1;
   logic          pll_mode = 1'b0;
   logic          pll_lock = 1'b0;
   logic [CW-1:0] cfg_in = 8'h11;
   logic          core_rst, flag_pon, flag_short, flag_long;
   logic [CW-1:0] cfg_q;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_en = 1'b0;

   always #2 clk = ~clk;

   hwrst_seq_ctrl #(.SEQ_LEN(SEQ), .CFG_W(CW)) u_dut (
      .clk(clk), .por(por), .rst_pin_n(pin_n), .pll_mode(pll_mode),
      .pll_lock(pll_lock), .cfg_in(cfg_in), .core_rst(core_rst),
      .cfg_q(cfg_q), .flag_pon(flag_pon), .flag_short(flag_short),
      .flag_long(flag_long)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference: history of pin samples plus elapsed-cycle bookkeeping
   int          m_hist[$];
   int          m_mode;   // 0 idle, 1 counting, 2 pin hold, 3 lock wait
   int          m_age, m_lim;
   bit          m_rst, m_sh, m_lg, m_pn;
   logic [CW-1:0] m_cfg;

   always @(posedge clk or posedge por) begin
      if (por) begin
         m_hist = '{1, 1};
         m_mode = 1; m_age = 0; m_lim = 2 * SEQ;
         m_rst = 1; m_sh = 0; m_lg = 0; m_pn = 1; m_cfg = '0;
      end else begin
         automatic int seen = m_hist[0];
         automatic bit stall = pll_mode && !pll_lock;
         if (m_rst && m_age >= SEQ - 1) m_cfg = cfg_in;
         case (m_mode)
            0: if (seen == 0) begin
                  m_mode = 1; m_age = -1; m_lim = SEQ; m_rst = 1;
                  m_sh = 0; m_lg = 0; m_pn = 0;
               end
            1: if (m_age == m_lim - 1) begin
                  if (seen == 0) begin m_lg = 1; m_mode = 2; end
                  else begin
                     m_sh = 1;
                     if (stall) m_mode = 3; else begin m_mode = 0; m_rst = 0; end
                  end
               end
            2: if (seen == 1) begin
                  if (stall) m_mode = 3; else begin m_mode = 0; m_rst = 0; end
               end
            default: if (!stall) begin m_mode = 0; m_rst = 0; end
         endcase
         m_age++;
         void'(m_hist.pop_front());
         m_hist.push_back(int'(pin_n));
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(core_rst === m_rst, "R3 core_rst vs model", int'(core_rst), int'(m_rst));
         chk(cfg_q === m_cfg, "R6 cfg_q vs model", int'(cfg_q), int'(m_cfg));
         chk({flag_pon, flag_short, flag_long} === {m_pn, m_sh, m_lg},
             "R8 flags vs model", int'({flag_pon, flag_short, flag_long}),
             int'({m_pn, m_sh, m_lg}));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int lo);
      pin_n = 1'b0;
      cyc(lo);
      pin_n = 1'b1;
   endtask

   task automatic measure(output int n);
      while (!core_rst) cyc(1);
      n = 0;
      while (core_rst) begin n++; cyc(1); end
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int n;
      cyc(5);
      // R2 reset state during power-on
      chk(core_rst === 1'b1, "R2 core_rst in por", int'(core_rst), 1);
      chk({flag_pon, flag_short, flag_long} === 3'b100, "R2 flags in por",
          int'({flag_pon, flag_short, flag_long}), 4);
      chk(cfg_q === 8'h00, "R2 cfg_q in por", int'(cfg_q), 0);
      por = 1'b0;
      cmp_en = 1'b1;
      n = 0;
      do begin cyc(1); n++; end while (core_rst);
      chk(n == 2 * SEQ, "R2 power-on length", n, 2 * SEQ);
      chk(cfg_q === 8'h11, "R6 cfg after por", int'(cfg_q), 8'h11);
      chk(flag_pon === 1'b1, "R9 pon kept", int'(flag_pon), 1);
      cyc(10);

      // short reset, closed then open config, R1 latency
      cfg_in = 8'h22;
      fork
         pulse(10);
         begin
            cyc(2);
            chk(core_rst === 1'b0, "R1 not before sync", int'(core_rst), 0);
            cyc(1);
            chk(core_rst === 1'b1, "R1 asserted after sync", int'(core_rst), 1);
            cyc(50);
            cfg_in = 8'h33;
            cyc(100);
            chk(cfg_q === 8'h11, "R6 closed period", int'(cfg_q), 8'h11);
            chk(flag_pon === 1'b0, "R8 pon cleared on new reset", int'(flag_pon), 0);
         end
         measure(n);
      join
      chk(n == SEQ, "R3 short length", n, SEQ);
      chk(flag_short === 1'b1 && flag_long === 1'b0, "R3 short flag",
          int'({flag_short, flag_long}), 2);
      chk(flag_pon === 1'b0, "R9 pin reset no pon", int'(flag_pon), 0);
      chk(cfg_q === 8'h33, "R6 value at release", int'(cfg_q), 8'h33);
      cfg_in = 8'h44;
      cyc(5);
      chk(cfg_q === 8'h33, "R6 ignored while running", int'(cfg_q), 8'h33);
      cyc(10);

      // renewed request inside the sequence
      fork
         begin pulse(10); cyc(200); pulse(5); end
         measure(n);
      join
      chk(n == SEQ, "R7 no restart", n, SEQ);
      cyc(10);

      // long reset with config following after the closed period
      fork
         pulse(700);
         begin cyc(600); cfg_in = 8'h55; cyc(50);
            chk(cfg_q === 8'h55, "R6 transparent in extension", int'(cfg_q), 8'h55); end
         measure(n);
      join
      chk(n == 700, "R4 long length", n, 700);
      chk(flag_long === 1'b1 && flag_short === 1'b0, "R4 long flag",
          int'({flag_short, flag_long}), 1);
      cyc(10);

      // lock stretch
      pll_mode = 1'b1;
      pll_lock = 1'b0;
      fork
         pulse(10);
         begin cyc(3 + SEQ + 40);
            chk(core_rst === 1'b1, "R5 held for lock", int'(core_rst), 1);
            pll_lock = 1'b1; end
         measure(n);
      join
      chk(n == SEQ + 41, "R5 release on lock", n, SEQ + 41);
      cyc(10);
      pll_mode = 1'b0;
      pll_lock = 1'b0;
      fork
         pulse(10);
         measure(n);
      join
      chk(n == SEQ, "R5 lock ignored without pll", n, SEQ);
      cyc(10);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule